// File: doc/BRIEF.md
# Burst Grant Accept Selector

This block is the per-input-lane stage of a parallel, iterative scheduler for optical burst switching. Each lane holds the descriptor of at most one burst for a scheduler run: the output fiber it must leave on, its arrival slot, its length and its service class. A central sequencer steps every lane through iterations, and through delay cycles within each iteration, one per fibre delay line. In a delay cycle the lane asks every wavelength of its target fiber at once. When grants come back, each carrying the gap (void) that allocation would leave in front of the burst, the lane takes the grant with the smallest gap and answers with a one-hot accept.

The lane stays silent for the rest of an iteration after it has accepted. Across iterations it remembers the delay, wavelength and void of its last accepted allocation. On the delay cycle equal to the remembered delay, its request carries the remembered void as a bound, so only a strictly tighter fit is taken. Delay cycles later than the remembered one are skipped, because the lane already holds a shorter delay. When the sequencer closes the last iteration, the lane latches its final allocation on result outputs.

The crossbar, the occupancy masks and the global sequencing live outside this block.

Top module: `burst_accept_lane`

## Requirements
- R1: After reset, req_valid, acc_valid and res_valid are 0 and acc_vec is all zeros.
- R2: A lane that holds no descriptor (exec_start without load_valid) never raises req_valid and reports res_valid = 0 at the end of the last iteration.
- R3: While cyc_req is high on a loaded lane, req_valid is 1 in the same cycle. req_mask has bits [fiber*NUM_WL +: NUM_WL] set and all other bits clear. req_slot, req_len and req_qos equal the loaded descriptor.
- R4: One clock after a grant_valid cycle that answers an outstanding request, acc_valid is 1 for one cycle. acc_vec is then one-hot on the eligible granted wavelength whose grant_void slice (wavelength w at bits [w*VOID_W +: VOID_W]) is smallest.
- R5: When two or more eligible grants report the same smallest void, the lowest wavelength index is accepted.
- R6: A grant_valid cycle with no request outstanding since the previous grant or iteration start produces no accept.
- R7: After an accept, the lane raises no request and takes no grant for the rest of that iteration, until iter_start.
- R8: A request carries req_bound = all ones, meaning no bound, except on the delay cycle equal to the retained delay of an earlier accept. There it carries the retained void.
- R9: Once an allocation is retained, requests in delay cycles with a higher index than the retained delay are suppressed.
- R10: A grant whose void is not strictly lower than a non-all-ones bound carried by its request is ignored. A strictly lower one is accepted and replaces the retained allocation.
- R11: On iter_end with last_iter high, res_valid, res_delay, res_wl and res_void take the retained allocation, with res_valid = 0 if nothing was ever accepted. They then hold until the next exec_start or load_valid.
- R12: load_valid clears the retained allocation and res_valid, so the next request carries an all-ones bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_start | input | 1 | Start of a scheduler run; empties the lane |
| load_valid | input | 1 | Load a burst descriptor (wins over exec_start) |
| load_fiber | input | FIB_W | Target output fiber |
| load_slot | input | SLOT_W | Arrival slot of the payload |
| load_len | input | LEN_W | Payload length |
| load_qos | input | QOS_W | Service class |
| iter_start | input | 1 | First cycle of an iteration; clears per-iteration state |
| cyc_req | input | 1 | Request phase of a delay cycle |
| cyc_delay | input | DLY_W | Delay line index of the current delay cycle |
| grant_valid | input | 1 | Grant vector and voids are valid |
| grant_vec | input | NUM_WL | Grants, one per wavelength of the target fiber |
| grant_void | input | NUM_WL*VOID_W | Void per granted wavelength |
| iter_end | input | 1 | Last cycle of an iteration |
| last_iter | input | 1 | Qualifies iter_end as the end of the final iteration |
| req_valid | output | 1 | Request raised this cycle |
| req_mask | output | NUM_FIB*NUM_WL | Requested output modules |
| req_slot | output | SLOT_W | Burst arrival slot sent with the request |
| req_len | output | LEN_W | Burst length sent with the request |
| req_qos | output | QOS_W | Service class sent with the request |
| req_bound | output | VOID_W | Void bound, all ones when none |
| acc_valid | output | 1 | Accept issued |
| acc_vec | output | NUM_WL | One-hot accepted wavelength |
| res_valid | output | 1 | Final allocation present |
| res_delay | output | DLY_W | Final delay line index |
| res_wl | output | WL_W | Final wavelength index |
| res_void | output | VOID_W | Final void bound |

## Verification
Corrupt retained state shows at the ports within one delay cycle of the next iteration. A wrong retained delay moves the non-all-ones req_bound to another delay cycle or suppresses the wrong requests. A wrong retained void changes req_bound and lets a grant through that should be ignored, or blocks one that should be taken. A lost per-iteration accept flag shows as a request raised right after an accept. A fault in the void comparison shows as the wrong one-hot accept one clock after the grant. All of these also reach res_void and res_wl at the close of the last iteration.

// File: rtl/burst_lane_pkg.sv
// Package: default geometry shared by the lane and its checker.
// Assumes: the values are powers of two so that index widths are exact.
package burst_lane_pkg;
    localparam int DEF_NUM_FIB    = 4;
    localparam int DEF_NUM_WL     = 4;
    localparam int DEF_NUM_DELAYS = 4;
    localparam int DEF_SLOT_W     = 8;
    localparam int DEF_LEN_W      = 8;
    localparam int DEF_QOS_W      = 2;
    localparam int DEF_VOID_W     = 8;

    // Width of an index over n items, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/lane_desc_store.sv
// Module: holds the single burst descriptor of the lane for one run.
// Assumes: load_valid wins over exec_start in the same cycle.
module lane_desc_store #(
    parameter int FIB_W  = 2,
    parameter int SLOT_W = 8,
    parameter int LEN_W  = 8,
    parameter int QOS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_start,
    input  logic              load_valid,
    input  logic [FIB_W-1:0]  load_fiber,
    input  logic [SLOT_W-1:0] load_slot,
    input  logic [LEN_W-1:0]  load_len,
    input  logic [QOS_W-1:0]  load_qos,
    output logic              occupied,
    output logic [FIB_W-1:0]  d_fiber,
    output logic [SLOT_W-1:0] d_slot,
    output logic [LEN_W-1:0]  d_len,
    output logic [QOS_W-1:0]  d_qos
);
    // Capture or drop the descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occupied <= 1'b0;
            d_fiber  <= '0;
            d_slot   <= '0;
            d_len    <= '0;
            d_qos    <= '0;
        end else if (load_valid) begin
            occupied <= 1'b1;
            d_fiber  <= load_fiber;
            d_slot   <= load_slot;
            d_len    <= load_len;
            d_qos    <= load_qos;
        end else if (exec_start) begin
            occupied <= 1'b0;
        end
    end
endmodule

// File: rtl/lane_req_gen.sv
// Module: forms the request of the current delay cycle.
// Requests fan out to every wavelength of the target fiber. They are blocked
// after an accept in this iteration and beyond a retained delay. The retained
// void goes out as the bound on the retained delay cycle.
// Assumes: iter_start in the same cycle as cyc_req opens a fresh iteration.
module lane_req_gen #(
    parameter int NUM_FIB = 4,
    parameter int NUM_WL  = 4,
    parameter int FIB_W   = 2,
    parameter int DLY_W   = 2,
    parameter int VOID_W  = 8
) (
    input  logic                      cyc_req,
    input  logic [DLY_W-1:0]          cyc_delay,
    input  logic                      occupied,
    input  logic [FIB_W-1:0]          fiber,
    input  logic                      acc_done,
    input  logic                      iter_start,
    input  logic                      ret_valid,
    input  logic [DLY_W-1:0]          ret_delay,
    input  logic [VOID_W-1:0]         ret_void,
    output logic                      req_valid,
    output logic [NUM_FIB*NUM_WL-1:0] req_mask,
    output logic [VOID_W-1:0]         req_bound
);
    logic blocked;
    logic beyond;

    // Decide whether a request goes out and which bound it carries.
    always_comb begin
        blocked   = acc_done && !iter_start;
        beyond    = ret_valid && (cyc_delay > ret_delay);
        req_valid = cyc_req && occupied && !blocked && !beyond;
        req_bound = (ret_valid && (cyc_delay == ret_delay)) ? ret_void : '1;
    end

    // One group of NUM_WL request lines per fiber.
    for (genvar f = 0; f < NUM_FIB; f++) begin : g_fib
        assign req_mask[f*NUM_WL +: NUM_WL] =
            (req_valid && (fiber == FIB_W'(f))) ? {NUM_WL{1'b1}} : {NUM_WL{1'b0}};
    end
endmodule

// File: rtl/lane_min_select.sv
// Module: picks the eligible grant with the smallest void.
// Ties go to the lowest index.
// Assumes: ineligible lanes are masked by the caller.
module lane_min_select #(
    parameter int NUM_WL = 4,
    parameter int VOID_W = 8,
    parameter int WL_W   = 2
) (
    input  logic [NUM_WL-1:0]        elig,
    input  logic [NUM_WL*VOID_W-1:0] voids,
    output logic                     found,
    output logic [WL_W-1:0]          best_idx,
    output logic [VOID_W-1:0]        best_void
);
    // Linear scan with strict compare keeps the lowest index on ties.
    always_comb begin
        found     = 1'b0;
        best_idx  = '0;
        best_void = '1;
        for (int i = 0; i < NUM_WL; i++) begin
            if (elig[i] && (!found || (voids[i*VOID_W +: VOID_W] < best_void))) begin
                found     = 1'b1;
                best_idx  = WL_W'(i);
                best_void = voids[i*VOID_W +: VOID_W];
            end
        end
    end
endmodule

// File: rtl/lane_alloc_state.sv
// Module: request bookkeeping, accept generation, the allocation retained
// across iterations and the final result.
// Assumes: the sequencer does not pulse iter_end together with a grant.
module lane_alloc_state #(
    parameter int NUM_WL = 4,
    parameter int DLY_W  = 2,
    parameter int WL_W   = 2,
    parameter int VOID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_start,
    input  logic              load_valid,
    input  logic              occupied,
    input  logic              iter_start,
    input  logic              cyc_req,
    input  logic [DLY_W-1:0]  cyc_delay,
    input  logic              req_valid,
    input  logic [VOID_W-1:0] req_bound,
    input  logic              grant_valid,
    input  logic              sel_found,
    input  logic [WL_W-1:0]   sel_idx,
    input  logic [VOID_W-1:0] sel_void,
    input  logic              iter_end,
    input  logic              last_iter,
    output logic [VOID_W-1:0] sent_bound,
    output logic              acc_done,
    output logic              ret_valid,
    output logic [DLY_W-1:0]  ret_delay,
    output logic [VOID_W-1:0] ret_void,
    output logic              acc_valid,
    output logic [NUM_WL-1:0] acc_vec,
    output logic              res_valid,
    output logic [DLY_W-1:0]  res_delay,
    output logic [WL_W-1:0]   res_wl,
    output logic [VOID_W-1:0] res_void
);
    logic             req_sent;
    logic [DLY_W-1:0] sent_delay;
    logic [WL_W-1:0]  ret_wl;
    logic             take;

    assign take = grant_valid && req_sent && sel_found;

    // Track the outstanding request, issue accepts, keep and publish the allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_sent   <= 1'b0;
            sent_delay <= '0;
            sent_bound <= '1;
            acc_done   <= 1'b0;
            ret_valid  <= 1'b0;
            ret_delay  <= '0;
            ret_void   <= '1;
            ret_wl     <= '0;
            acc_valid  <= 1'b0;
            acc_vec    <= '0;
            res_valid  <= 1'b0;
            res_delay  <= '0;
            res_wl     <= '0;
            res_void   <= '0;
        end else begin
            acc_valid <= 1'b0;
            acc_vec   <= '0;
            if (cyc_req) begin
                req_sent   <= req_valid;
                sent_delay <= cyc_delay;
                sent_bound <= req_bound;
            end else if (grant_valid || iter_start) begin
                req_sent <= 1'b0;
            end
            if (iter_start) begin
                acc_done <= 1'b0;
            end
            if (take) begin
                acc_valid        <= 1'b1;
                acc_vec[sel_idx] <= 1'b1;
                acc_done         <= 1'b1;
                ret_valid        <= 1'b1;
                ret_delay        <= sent_delay;
                ret_void         <= sel_void;
                ret_wl           <= sel_idx;
            end
            if (iter_end && last_iter) begin
                res_valid <= occupied && ret_valid;
                res_delay <= ret_valid ? ret_delay : '0;
                res_wl    <= ret_valid ? ret_wl : '0;
                res_void  <= ret_valid ? ret_void : '0;
            end
            if (exec_start || load_valid) begin
                req_sent  <= 1'b0;
                acc_done  <= 1'b0;
                ret_valid <= 1'b0;
                ret_delay <= '0;
                ret_void  <= '1;
                ret_wl    <= '0;
                res_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/burst_accept_lane.sv
// Module: top of one input lane of the iterative burst scheduler.
// It stores a descriptor, requests all wavelengths of the target fiber and
// accepts the smallest-void grant. The accept honours the bound carried by
// the request.
// Assumes: grants answer the most recent request of this lane.
module burst_accept_lane
    import burst_lane_pkg::*;
#(
    parameter int NUM_FIB    = DEF_NUM_FIB,
    parameter int NUM_WL     = DEF_NUM_WL,
    parameter int NUM_DELAYS = DEF_NUM_DELAYS,
    parameter int SLOT_W     = DEF_SLOT_W,
    parameter int LEN_W      = DEF_LEN_W,
    parameter int QOS_W      = DEF_QOS_W,
    parameter int VOID_W     = DEF_VOID_W,
    localparam int FIB_W     = idx_w(NUM_FIB),
    localparam int WL_W      = idx_w(NUM_WL),
    localparam int DLY_W     = idx_w(NUM_DELAYS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      exec_start,
    input  logic                      load_valid,
    input  logic [FIB_W-1:0]          load_fiber,
    input  logic [SLOT_W-1:0]         load_slot,
    input  logic [LEN_W-1:0]          load_len,
    input  logic [QOS_W-1:0]          load_qos,
    input  logic                      iter_start,
    input  logic                      cyc_req,
    input  logic [DLY_W-1:0]          cyc_delay,
    input  logic                      grant_valid,
    input  logic [NUM_WL-1:0]         grant_vec,
    input  logic [NUM_WL*VOID_W-1:0]  grant_void,
    input  logic                      iter_end,
    input  logic                      last_iter,
    output logic                      req_valid,
    output logic [NUM_FIB*NUM_WL-1:0] req_mask,
    output logic [SLOT_W-1:0]         req_slot,
    output logic [LEN_W-1:0]          req_len,
    output logic [QOS_W-1:0]          req_qos,
    output logic [VOID_W-1:0]         req_bound,
    output logic                      acc_valid,
    output logic [NUM_WL-1:0]         acc_vec,
    output logic                      res_valid,
    output logic [DLY_W-1:0]          res_delay,
    output logic [WL_W-1:0]           res_wl,
    output logic [VOID_W-1:0]         res_void
);
    logic              occupied;
    logic [FIB_W-1:0]  d_fiber;
    logic              acc_done;
    logic              ret_valid;
    logic [DLY_W-1:0]  ret_delay;
    logic [VOID_W-1:0] ret_void;
    logic [VOID_W-1:0] sent_bound;
    logic [NUM_WL-1:0] elig;
    logic              sel_found;
    logic [WL_W-1:0]   sel_idx;
    logic [VOID_W-1:0] sel_void;

    lane_desc_store #(
        .FIB_W(FIB_W), .SLOT_W(SLOT_W), .LEN_W(LEN_W), .QOS_W(QOS_W)
    ) u_desc (
        .clk(clk), .rst_n(rst_n), .exec_start(exec_start), .load_valid(load_valid),
        .load_fiber(load_fiber), .load_slot(load_slot), .load_len(load_len),
        .load_qos(load_qos), .occupied(occupied), .d_fiber(d_fiber),
        .d_slot(req_slot), .d_len(req_len), .d_qos(req_qos)
    );

    lane_req_gen #(
        .NUM_FIB(NUM_FIB), .NUM_WL(NUM_WL), .FIB_W(FIB_W), .DLY_W(DLY_W), .VOID_W(VOID_W)
    ) u_req (
        .cyc_req(cyc_req), .cyc_delay(cyc_delay), .occupied(occupied), .fiber(d_fiber),
        .acc_done(acc_done), .iter_start(iter_start), .ret_valid(ret_valid),
        .ret_delay(ret_delay), .ret_void(ret_void), .req_valid(req_valid),
        .req_mask(req_mask), .req_bound(req_bound)
    );

    // A granted wavelength is eligible when no bound was sent or it beats the bound.
    for (genvar w = 0; w < NUM_WL; w++) begin : g_elig
        assign elig[w] = grant_vec[w] &&
            ((sent_bound == {VOID_W{1'b1}}) || (grant_void[w*VOID_W +: VOID_W] < sent_bound));
    end

    lane_min_select #(
        .NUM_WL(NUM_WL), .VOID_W(VOID_W), .WL_W(WL_W)
    ) u_sel (
        .elig(elig), .voids(grant_void), .found(sel_found),
        .best_idx(sel_idx), .best_void(sel_void)
    );

    lane_alloc_state #(
        .NUM_WL(NUM_WL), .DLY_W(DLY_W), .WL_W(WL_W), .VOID_W(VOID_W)
    ) u_alloc (
        .clk(clk), .rst_n(rst_n), .exec_start(exec_start), .load_valid(load_valid),
        .occupied(occupied), .iter_start(iter_start), .cyc_req(cyc_req),
        .cyc_delay(cyc_delay), .req_valid(req_valid), .req_bound(req_bound),
        .grant_valid(grant_valid), .sel_found(sel_found), .sel_idx(sel_idx),
        .sel_void(sel_void), .iter_end(iter_end), .last_iter(last_iter),
        .sent_bound(sent_bound), .acc_done(acc_done), .ret_valid(ret_valid),
        .ret_delay(ret_delay), .ret_void(ret_void), .acc_valid(acc_valid),
        .acc_vec(acc_vec), .res_valid(res_valid), .res_delay(res_delay),
        .res_wl(res_wl), .res_void(res_void)
    );
endmodule

// File: rtl/burst_accept_lane_chk.sv
// Module: protocol checker bound to every burst_accept_lane instance.
// Assumes: synchronous active-low reset; observes ports and the occupancy flag.
module burst_accept_lane_chk #(
    parameter int NUM_FIB = 4,
    parameter int NUM_WL  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      occupied,
    input logic                      req_valid,
    input logic [NUM_FIB*NUM_WL-1:0] req_mask,
    input logic                      grant_valid,
    input logic                      acc_valid,
    input logic [NUM_WL-1:0]         acc_vec,
    input logic                      iter_start,
    input logic                      iter_end,
    input logic                      exec_start,
    input logic                      load_valid,
    input logic                      res_valid
);
    AST_REQ_NEEDS_DESC: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> occupied); // R2
    AST_REQ_FANOUT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($countones(req_mask) == NUM_WL)); // R3
    AST_REQ_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (req_mask == '0)); // R3
    AST_ACC_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> ($countones(acc_vec) == 1)); // R4
    AST_ACC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (acc_vec == '0)); // R4
    AST_ACC_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $past(grant_valid)); // R6
    AST_QUIET_AFTER_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !iter_start) |-> !req_valid); // R7
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!iter_end && !exec_start && !load_valid) |=> $stable(res_valid)); // R11
endmodule

bind burst_accept_lane burst_accept_lane_chk #(
    .NUM_FIB(NUM_FIB), .NUM_WL(NUM_WL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .occupied(occupied), .req_valid(req_valid),
    .req_mask(req_mask), .grant_valid(grant_valid), .acc_valid(acc_valid),
    .acc_vec(acc_vec), .iter_start(iter_start), .iter_end(iter_end),
    .exec_start(exec_start), .load_valid(load_valid), .res_valid(res_valid)
);

// File: tb/burst_accept_lane_tb.sv
`timescale 1ns/1ps
module burst_accept_lane_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_start = 1'b0, load_valid = 1'b0;
    logic [1:0]  load_fiber = '0;
    logic [7:0]  load_slot = '0, load_len = '0;
    logic [1:0]  load_qos = '0;
    logic        iter_start = 1'b0, cyc_req = 1'b0;
    logic [1:0]  cyc_delay = '0;
    logic        grant_valid = 1'b0;
    logic [3:0]  grant_vec = '0;
    logic [31:0] grant_void = '0;
    logic        iter_end = 1'b0, last_iter = 1'b0;
    logic        req_valid;
    logic [15:0] req_mask;
    logic [7:0]  req_slot, req_len;
    logic [1:0]  req_qos;
    logic [7:0]  req_bound;
    logic        acc_valid;
    logic [3:0]  acc_vec;
    logic        res_valid;
    logic [1:0]  res_delay, res_wl;
    logic [7:0]  res_void;

    int checks = 0;
    int failures = 0;

    burst_accept_lane u_dut (
        .clk(clk), .rst_n(rst_n), .exec_start(exec_start), .load_valid(load_valid),
        .load_fiber(load_fiber), .load_slot(load_slot), .load_len(load_len),
        .load_qos(load_qos), .iter_start(iter_start), .cyc_req(cyc_req),
        .cyc_delay(cyc_delay), .grant_valid(grant_valid), .grant_vec(grant_vec),
        .grant_void(grant_void), .iter_end(iter_end), .last_iter(last_iter),
        .req_valid(req_valid), .req_mask(req_mask), .req_slot(req_slot),
        .req_len(req_len), .req_qos(req_qos), .req_bound(req_bound),
        .acc_valid(acc_valid), .acc_vec(acc_vec), .res_valid(res_valid),
        .res_delay(res_delay), .res_wl(res_wl), .res_void(res_void)
    );

    always #10 clk = ~clk; // 50 MHz

    // Table: grant vector, voids w3..w0, expected accept, expected void.
    localparam logic [47:0] VECS [6] = '{
        {4'b1111, 8'd9,   8'd7, 8'd5,  8'd10,  4'b0010, 8'd5},
        {4'b1010, 8'd3,   8'd0, 8'd20, 8'd1,   4'b1000, 8'd3},
        {4'b0110, 8'd0,   8'd4, 8'd4,  8'd0,   4'b0010, 8'd4},
        {4'b0000, 8'd1,   8'd1, 8'd1,  8'd1,   4'b0000, 8'hFF},
        {4'b1001, 8'd254, 8'd0, 8'd0,  8'd255, 4'b1000, 8'd254},
        {4'b1111, 8'd0,   8'd0, 8'd0,  8'd0,   4'b0001, 8'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_load(input logic with_exec, input logic [1:0] fib,
                              input logic [7:0] slot, input logic [7:0] len, input logic [1:0] qos);
        exec_start = with_exec; load_valid = 1'b1;
        load_fiber = fib; load_slot = slot; load_len = len; load_qos = qos;
        tick();
        exec_start = 1'b0; load_valid = 1'b0;
    endtask

    task automatic pulse_iter();
        iter_start = 1'b1; tick(); iter_start = 1'b0;
    endtask

    task automatic end_iter(input logic last);
        iter_end = 1'b1; last_iter = last; tick(); iter_end = 1'b0; last_iter = 1'b0;
    endtask

    // Raise a delay-cycle request; the caller checks outputs before the edge.
    task automatic req_on(input logic [1:0] d);
        cyc_req = 1'b1; cyc_delay = d; #1;
    endtask

    task automatic req_off();
        tick(); cyc_req = 1'b0;
    endtask

    task automatic grant(input logic [3:0] v, input logic [31:0] voids);
        grant_valid = 1'b1; grant_vec = v; grant_void = voids;
        tick();
        grant_valid = 1'b0; grant_vec = '0;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_valid", req_valid, 0);
        chk("R1 acc_valid", acc_valid, 0);
        chk("R1 acc_vec", acc_vec, 0);
        chk("R1 res_valid", res_valid, 0);

        // Table-driven accept selection: fresh run, delay 0, one grant.
        for (int k = 0; k < 6; k++) begin
            logic [47:0] e;
            logic [1:0]  ew;
            e = VECS[k];
            ew = 2'd0;
            for (int b = 0; b < 4; b++) if (e[8+b]) ew = 2'(b);
            pulse_load(1'b1, 2'(k % 4), 8'(k), 8'd50, 2'd0);
            pulse_iter();
            req_on(2'd0);
            chk("R3 table req_valid", req_valid, 1);
            req_off();
            grant(e[47:44], e[43:12]);
            chk("R4 R5 table acc_vec", acc_vec, e[11:8]);
            chk("R4 table acc_valid", acc_valid, (e[11:8] != 0));
            end_iter(1'b1);
            chk("R11 table res_valid", res_valid, (e[11:8] != 0));
            if (e[11:8] != 0) begin
                chk("R11 table res_void", res_void, e[7:0]);
                chk("R11 table res_wl", res_wl, ew);
                chk("R11 table res_delay", res_delay, 0);
            end
        end

        // R2: empty lane never requests and reports no result.
        exec_start = 1'b1; tick(); exec_start = 1'b0;
        pulse_iter();
        req_on(2'd0);
        chk("R2 empty req_valid", req_valid, 0);
        chk("R2 empty req_mask", req_mask, 0);
        req_off();
        end_iter(1'b1);
        chk("R2 empty res_valid", res_valid, 0);

        // R3/R6/R7: load on fiber 2, first iteration.
        pulse_load(1'b1, 2'd2, 8'h33, 8'h44, 2'd3);
        pulse_iter();
        grant(4'b1111, 32'h0);
        chk("R6 grant without request", acc_valid, 0);
        req_on(2'd0);
        chk("R3 req_mask", req_mask, 16'h0F00);
        chk("R3 req_slot", req_slot, 8'h33);
        chk("R3 req_len", req_len, 8'h44);
        chk("R3 req_qos", req_qos, 3);
        chk("R8 first iter bound", req_bound, 8'hFF);
        req_off();
        req_on(2'd1);
        chk("R3 delay1 req_valid", req_valid, 1);
        req_off();
        grant(4'b0100, {8'd0, 8'd6, 8'd0, 8'd0});
        chk("R4 single grant acc", acc_vec, 4'b0100);
        req_on(2'd2);
        chk("R7 no request after accept", req_valid, 0);
        req_off();
        grant(4'b1111, 32'h0);
        chk("R7 no accept after accept", acc_valid, 0);
        end_iter(1'b0);

        // R8/R9/R10: second iteration with retained delay 1, void 6.
        pulse_iter();
        req_on(2'd0);
        chk("R8 delay0 req_valid", req_valid, 1);
        chk("R8 delay0 bound", req_bound, 8'hFF);
        req_off();
        req_on(2'd1);
        chk("R8 retained bound", req_bound, 8'd6);
        req_off();
        grant(4'b0011, {8'd0, 8'd0, 8'd7, 8'd6});
        chk("R10 no strict improvement", acc_valid, 0);
        req_on(2'd2);
        chk("R9 beyond retained delay", req_valid, 0);
        req_off();
        end_iter(1'b0);

        // R10/R11: third iteration improves to void 5 on wavelength 2.
        pulse_iter();
        req_on(2'd1);
        chk("R10 bound again", req_bound, 8'd6);
        req_off();
        grant(4'b0100, {8'd0, 8'd5, 8'd0, 8'd0});
        chk("R10 improvement accepted", acc_vec, 4'b0100);
        end_iter(1'b1);
        chk("R11 res_valid", res_valid, 1);
        chk("R11 res_delay", res_delay, 1);
        chk("R11 res_wl", res_wl, 2);
        chk("R11 res_void", res_void, 5);
        repeat (3) tick();
        end_iter(1'b0);
        chk("R11 result held", res_valid, 1);
        chk("R11 void held", res_void, 5);

        // R12: a new load clears the result and the retained bound.
        pulse_load(1'b0, 2'd0, 8'h01, 8'h02, 2'd1);
        chk("R12 res cleared", res_valid, 0);
        pulse_iter();
        req_on(2'd1);
        chk("R12 req_valid", req_valid, 1);
        chk("R12 bound reset", req_bound, 8'hFF);
        chk("R12 mask fiber0", req_mask, 16'h000F);
        req_off();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule